// File: doc/BRIEF.md
# Scatter Segment Length Splitter

This block sits between a list of scatter-gather entries and a DMA channel whose transfer counter holds at most 13 bits. Each entry carries a start address and a byte length. An entry that fits the counter goes out unchanged as one segment. A longer entry is cut into pieces of nearly equal, 4-byte-aligned size, so the list never ends with a small leftover segment.

Entries arrive on a valid/ready input, one at a time. Segments leave on a valid/ready output. The input stays blocked while an entry is being cut, because the piece sizes come from a shared sequential divider. The last segment of a list is flagged. One cycle after that segment is accepted, a done pulse appears together with the byte total of the list. Entries with a misaligned address are rejected with an error pulse. A marker for an empty list is also rejected with an error pulse.

Top module: `seg_splitter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, done and err are 0.
- R2: An aligned entry with a length of at most 0x1FFF (including length 0) leaves as exactly one segment with the same address and length.
- R3: For a remaining length above 0x1FFF, the piece count is ceil(remaining / 0x1FFC) and the piece length is (remaining / count) with its two low bits cleared. This is recomputed for every piece. Once the remaining length is at most 0x1FFF, it is emitted whole as the final piece of the entry.
- R4: Each later piece of an entry starts at the previous piece's address plus the previous piece's length, and the piece lengths add up to the entry length.
- R5: An entry whose address bits [1:0] are not both zero is consumed without producing any segment, and err is 1 in the cycle after it is accepted.
- R6: An input with in_empty set stands for a list of zero entries. It is consumed without producing any segment, and err is 1 in the cycle after it is accepted.
- R7: out_last is 1 only on the final segment of an entry presented with in_last. In the cycle after that segment is accepted, done is 1 and total equals the sum of all segment lengths of the list.
- R8: in_ready is 0 from the cycle after a valid aligned entry is accepted until the cycle after that entry's final segment is accepted.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_addr, out_len and out_last hold their values into the next cycle.
- R10: Every segment address has bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Block can take an entry |
| in_addr | input | AW | Entry start address |
| in_len | input | LEN_W | Entry byte length |
| in_last | input | 1 | Entry ends its list |
| in_empty | input | 1 | Marker for a list with no entries |
| out_valid | output | 1 | Segment offered |
| out_ready | input | 1 | Consumer takes the segment |
| out_addr | output | AW | Segment start address |
| out_len | output | SEG_W | Segment byte length |
| out_last | output | 1 | Final segment of the list |
| done | output | 1 | One-cycle pulse after the list's last segment |
| total | output | TOT_W | Byte total of the finished list |
| err | output | 1 | One-cycle pulse for a rejected input |

## Verification
The assertions assume two things about the inputs. A producer keeps in_empty low on real entries, and it never offers lengths wider than LEN_W. Each list either ends with an in_last entry or is closed by a rejection. The stimulus offers one entry at a time and waits until in_ready returns before offering the next. On some entries it applies a periodic backpressure pattern on out_ready, which exercises segment holding. Length 0, exactly 0x1FFF, just above 0x1FFF and the largest LEN_W value are all covered.

// File: rtl/seg_splitter.sv
module seg_splitter #(
  parameter int AW         = 32,
  parameter int LEN_W      = 16,
  parameter int SEG_W      = 13,
  parameter int ALIGN_BITS = 2,
  parameter int TOT_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [AW-1:0]    in_addr,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_last,
  input  logic             in_empty,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    out_addr,
  output logic [SEG_W-1:0] out_len,
  output logic             out_last,
  output logic             done,
  output logic [TOT_W-1:0] total,
  output logic             err
);
  localparam int DW = LEN_W + 1;
  localparam int CW = $clog2(DW + 1);
  localparam logic [LEN_W-1:0] MAXL   = LEN_W'((1 << SEG_W) - 1);
  localparam logic [LEN_W-1:0] ALMASK = LEN_W'((1 << ALIGN_BITS) - 1);
  localparam logic [DW-1:0]    AMAXD  = DW'(((1 << SEG_W) - 1) & ~((1 << ALIGN_BITS) - 1));

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_EMIT} st_t;
  st_t st;

  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] rem_q, piece_q;
  logic             fin_q, last_q, phase_q;
  logic [CW-1:0]    cnt_q;
  logic [DW-1:0]    num_q, den_q;
  logic [DW:0]      part_q;
  logic [TOT_W-1:0] acc_q, total_q;
  logic             done_q, err_q;

  logic             take, fire, misal, ge;
  logic [DW:0]      shifted;
  logic [DW-1:0]    quot;
  logic [LEN_W-1:0] rem_after;

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_EMIT);
  assign out_addr  = addr_q;
  assign out_len   = piece_q[SEG_W-1:0];
  assign out_last  = last_q & fin_q;
  assign done      = done_q;
  assign total     = total_q;
  assign err       = err_q;

  assign take      = in_valid & in_ready;
  assign fire      = out_valid & out_ready;
  assign misal     = |in_addr[ALIGN_BITS-1:0];
  assign shifted   = {part_q[DW-1:0], num_q[DW-1]};
  assign ge        = shifted >= {1'b0, den_q};
  assign quot      = {num_q[DW-2:0], ge};
  assign rem_after = rem_q - piece_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      piece_q <= '0;
      fin_q   <= 1'b0;
      last_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      num_q   <= '0;
      den_q   <= '0;
      part_q  <= '0;
      acc_q   <= '0;
      total_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (in_empty || misal) begin
            err_q <= 1'b1;
            if (in_empty || in_last) acc_q <= '0;
          end else begin
            addr_q <= in_addr;
            rem_q  <= in_len;
            last_q <= in_last;
            if (in_len <= MAXL) begin
              piece_q <= in_len;
              fin_q   <= 1'b1;
              st      <= S_EMIT;
            end else begin
              num_q   <= {1'b0, in_len} + AMAXD - DW'(1);
              den_q   <= AMAXD;
              part_q  <= '0;
              cnt_q   <= '0;
              phase_q <= 1'b0;
              fin_q   <= 1'b0;
              st      <= S_DIV;
            end
          end
        end
        S_DIV: begin
          if (cnt_q == CW'(DW - 1)) begin
            part_q <= '0;
            cnt_q  <= '0;
            if (!phase_q) begin
              num_q   <= {1'b0, rem_q};
              den_q   <= quot;
              phase_q <= 1'b1;
            end else begin
              piece_q <= quot[LEN_W-1:0] & ~ALMASK;
              st      <= S_EMIT;
            end
          end else begin
            part_q <= ge ? shifted - {1'b0, den_q} : shifted;
            num_q  <= quot;
            cnt_q  <= cnt_q + CW'(1);
          end
        end
        S_EMIT: if (fire) begin
          addr_q <= addr_q + AW'(piece_q);
          rem_q  <= rem_after;
          if (out_last) begin
            total_q <= acc_q + TOT_W'(piece_q);
            acc_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            acc_q <= acc_q + TOT_W'(piece_q);
          end
          if (fin_q) begin
            st <= S_IDLE;
          end else if (rem_after <= MAXL) begin
            piece_q <= rem_after;
            fin_q   <= 1'b1;
          end else begin
            num_q   <= {1'b0, rem_after} + AMAXD - DW'(1);
            den_q   <= AMAXD;
            part_q  <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            st      <= S_DIV;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_splitter_chk.sv
module seg_splitter_chk #(
  parameter int AW         = 32,
  parameter int LEN_W      = 16,
  parameter int SEG_W      = 13,
  parameter int ALIGN_BITS = 2,
  parameter int TOT_W      = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [AW-1:0]    in_addr,
  input logic [LEN_W-1:0] in_len,
  input logic             in_last,
  input logic             in_empty,
  input logic             out_valid,
  input logic             out_ready,
  input logic [AW-1:0]    out_addr,
  input logic [SEG_W-1:0] out_len,
  input logic             out_last,
  input logic             done,
  input logic [TOT_W-1:0] total,
  input logic             err
);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'((1 << SEG_W) - 1);
  logic acc_ok;
  assign acc_ok = in_valid && in_ready && !in_empty && (in_addr[ALIGN_BITS-1:0] == '0);

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (in_len <= MAXL) |=> out_valid && (LEN_W'(out_len) == $past(in_len)) && (out_addr == $past(in_addr)));

  p_misalign_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_empty && (in_addr[ALIGN_BITS-1:0] != '0) |=> err && in_ready && !out_valid);

  p_empty_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_empty |=> err && !out_valid);

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last));

  p_ready_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_last));

  p_addr_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[ALIGN_BITS-1:0] == '0));
endmodule

bind seg_splitter seg_splitter_chk #(
  .AW(AW), .LEN_W(LEN_W), .SEG_W(SEG_W), .ALIGN_BITS(ALIGN_BITS), .TOT_W(TOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .in_len(in_len), .in_last(in_last), .in_empty(in_empty),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_len(out_len), .out_last(out_last), .done(done), .total(total), .err(err)
);

// File: tb/seg_splitter_bench.sv
`timescale 1ns/1ps
module seg_splitter_bench;
  localparam int AW = 32, LEN_W = 16, SEG_W = 13, ALIGN_BITS = 2, TOT_W = 24;
  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h2000, 32'h4000, 32'h8000,
                                          32'h10000, 32'h20000, 32'h30000};
  localparam logic [15:0] V_LEN  [NV] = '{16'h0100, 16'h1FFF, 16'h2000, 16'h5000,
                                          16'hFFFF, 16'h2001, 16'h0000};
  localparam bit          V_LAST [NV] = '{0, 0, 0, 1, 1, 1, 1};
  localparam bit          V_BP   [NV] = '{0, 1, 0, 1, 1, 0, 0};
  localparam int          V_NSEG [NV] = '{1, 1, 2, 3, 9, 2, 1};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_empty = 0, out_ready = 1;
  logic [AW-1:0] in_addr = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic in_ready, out_valid, out_last, done, err;
  logic [AW-1:0] out_addr;
  logic [SEG_W-1:0] out_len;
  logic [TOT_W-1:0] total;
  int checks = 0, fails = 0, cyc = 0;
  longint list_sum = 0;

  always #4 clk = ~clk;

  seg_splitter u_seg_splitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_last(in_last), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_len(out_len), .out_last(out_last), .done(done), .total(total), .err(err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint piece_of(input longint rem);
    longint c;
    if (rem <= 8191) return rem;
    c = (rem + 8187) / 8188;
    return (rem / c) & ~longint'(3);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_entry(input logic [31:0] a0, input logic [15:0] len, input bit last,
                           input bit bp, input int nseg, input string tag);
    longint rem = len, a = a0, p;
    int n = 0, guard = 0;
    bit fin = 0, held = 0, rdy_bad = 0, hold_bad = 0, pos_bad = 0;
    logic [AW-1:0] h_addr; logic [SEG_W-1:0] h_len; logic h_last;
    @(negedge clk);
    check(in_ready == 1, "R8 idle ready", in_ready, 1);
    in_valid = 1; in_addr = a0; in_len = len; in_last = last; in_empty = 0;
    @(negedge clk);
    in_valid = 0;
    while (!fin && guard < 5000) begin
      out_ready = bp ? (guard % 3 != 1) : 1'b1;
      if (in_ready) rdy_bad = 1;
      if (held && (!out_valid || out_addr != h_addr || out_len != h_len || out_last != h_last))
        hold_bad = 1;
      held = out_valid && !out_ready;
      h_addr = out_addr; h_len = out_len; h_last = out_last;
      if (out_valid && out_ready) begin
        p = piece_of(rem);
        if (longint'(out_addr) != a || longint'(out_len) != p ||
            out_last != (last && (rem == p))) begin
          pos_bad = 1;
          $display("  %s seg %0d: addr 0x%0h/0x%0h len 0x%0h/0x%0h", tag, n, out_addr, a, out_len, p);
        end
        a += p; rem -= p; n++;
        list_sum += p;
        if (rem == 0) fin = 1;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1;
    check(!pos_bad, {tag, " R2 R3 R4 segment addr/len"}, pos_bad, 0);
    check(n == nseg, {tag, " R3 segment count"}, n, nseg);
    check(!rdy_bad, {tag, " R8 in_ready low while splitting"}, rdy_bad, 0);
    if (bp) check(!hold_bad, {tag, " R9 hold under backpressure"}, hold_bad, 0);
    check(in_ready == 1, {tag, " R8 ready returns"}, in_ready, 1);
    if (last) begin
      check(done == 1 && longint'(total) == list_sum, {tag, " R7 done and total"}, total, list_sum);
      list_sum = 0;
    end else begin
      check(done == 0, {tag, " R7 no done mid-list"}, done, 0);
    end
  endtask

  task automatic reject(input logic [31:0] a0, input bit last, input bit empty, input string tag);
    bit bad = 0;
    @(negedge clk);
    in_valid = 1; in_addr = a0; in_len = 16'h0040; in_last = last; in_empty = empty;
    @(negedge clk);
    in_valid = 0; in_empty = 0;
    check(err == 1, {tag, " err pulse"}, err, 1);
    for (int i = 0; i < 6; i++) begin
      if (out_valid || !in_ready) bad = 1;
      @(negedge clk);
    end
    check(!bad, {tag, " no segment emitted"}, bad, 0);
    check(err == 0, {tag, " err is a pulse"}, err, 0);
    if (last || empty) list_sum = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1 && out_valid == 0 && done == 0 && err == 0, "R1 reset state",
          {in_ready, out_valid, done, err}, 4'b1000);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      run_entry(V_ADDR[i], V_LEN[i], V_LAST[i], V_BP[i], V_NSEG[i], $sformatf("vec%0d", i));
    reject(32'h0000_5002, 0, 0, "R5 misaligned addr");
    reject(32'h0000_5001, 1, 0, "R5 misaligned last");
    reject(32'h0000_6000, 0, 1, "R6 empty list");
    run_entry(32'h0004_0004, 16'h3FF8, 1, 1, 2, "R3 R10 offset oversized");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule